// File: doc/BRIEF.md
# Multi-Agent Hardware Semaphore Bank

This block arbitrates ownership of a set of shared resources among several independent software agents. Each agent has its own ownership word, where bit n set means the agent holds resource n. The hardware guarantees that a resource bit is held by at most one agent at any time. An agent claims resources by writing a mask to its acquire port. It then reads its word back to learn which of the requested bits were actually granted. It gives resources back by writing a mask to its release port.

Each agent window is two words wide. The release port sits at window offset 0 and the acquire port at offset 4, and a read from either port returns the agent's ownership word. The first group of agents is packed from one base address and the remaining agents from a second, separate base. Two kinds of misuse set a sticky interrupt: acquiring a bit the agent already owns, and releasing a bit it does not own. Software clears the interrupt by writing 1 to a dedicated clear address. The register bus performs at most one access per clock, so concurrent agents are serialised before they reach the bank.

Top module: `hwsem_bank`

## Requirements
- R1: After reset every agent's ownership word reads 0 and `irq` is 0.
- R2: A given resource bit is set in at most one agent's ownership word at any time.
- R3: A write to an agent's acquire port (window offset 4) sets each requested bit that no other agent holds, and the next read of that agent shows the bit as 1.
- R4: A requested bit that another agent holds stays 0 for the requester, leaves the holder unchanged and raises no interrupt.
- R5: The bits of one write are handled independently, so one acquire may grant some bits and refuse others.
- R6: An acquire that requests a bit the same agent already owns sets `irq` and leaves the word unchanged for that bit.
- R7: A write to an agent's release port (window offset 0) clears every bit that is 1 in the write data.
- R8: A release that names a bit the agent does not own sets `irq`.
- R9: Agent a (a < LO_COUNT) has its window at BASE_A + 8a; agent a >= LO_COUNT has its window at BASE_B + 8(a - LO_COUNT). Reads from both ports of a window return the same word.
- R10: Writes to an address outside every window, or whose low two bits are nonzero, or to the interrupt-clear address change no ownership word. Reads from such addresses return 0.
- R11: A read request causes `rd_valid` to be 1 with `rd_data` exactly one cycle later, reflecting any write made in an earlier cycle. `rd_valid` is 0 in every other cycle.
- R12: `irq` stays 1 until a write with data bit 0 equal to 1 reaches IRQ_CLR_ADDR. A write there with bit 0 equal to 0 has no effect, and `irq` never rises without a misuse write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | NUM_RES (32) | Write data: resource mask, or bit 0 for interrupt clear |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | NUM_RES (32) | Read data |
| irq | output | 1 | Sticky misuse interrupt |

## Verification
The assertions assume that `bus_sel`, `bus_wr` and `bus_addr` are free of X while out of reset. They also assume that a request is held for exactly one cycle, so a read and a write never overlap, and that writes arrive only through the bus port. The stimulus drives every access from a single task, one cycle wide, on the falling edge, followed by an idle cycle, so requests never overlap and every read lands in the cycle where R11 expects it. Contention is produced by issuing requests from different agents one after another, because the bus itself serialises them.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2
  } sem_op_e;
endpackage

// File: rtl/hwsem_decode.sv
module hwsem_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_AGENTS = 16,
  parameter int LO_COUNT = 6,
  parameter int AGENT_W = 4,
  parameter logic [ADDR_W-1:0] BASE_A = 16'hA360,
  parameter logic [ADDR_W-1:0] BASE_B = 16'hA3C8
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic               set_port,
  output logic [AGENT_W-1:0] agent
);
  localparam int HI_COUNT = NUM_AGENTS - LO_COUNT;
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(LO_COUNT * 8);
  localparam logic [ADDR_W-1:0] SPAN_B = ADDR_W'(HI_COUNT * 8);

  logic [ADDR_W-1:0] off_a, off_b;
  logic in_a, in_b, aligned;

  always_comb begin
    off_a   = addr - BASE_A;
    off_b   = addr - BASE_B;
    aligned = (addr[1:0] == 2'b00);
    in_a    = (addr >= BASE_A) && (off_a < SPAN_A);
    in_b    = (addr >= BASE_B) && (off_b < SPAN_B);
    hit     = aligned && (in_a || in_b);
    if (in_a) begin
      agent    = AGENT_W'(off_a >> 3);
      set_port = off_a[2];
    end else begin
      agent    = AGENT_W'(LO_COUNT) + AGENT_W'(off_b >> 3);
      set_port = off_b[2];
    end
  end
endmodule

// File: rtl/hwsem_owner_bank.sv
module hwsem_owner_bank
  import hwsem_pkg::*;
#(
  parameter int NUM_AGENTS = 16,
  parameter int NUM_RES = 32,
  parameter int AGENT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  sem_op_e                       op,
  input  logic [AGENT_W-1:0]            agent,
  input  logic [NUM_RES-1:0]            mask,
  output logic [NUM_AGENTS*NUM_RES-1:0] own_flat,
  output logic                          misuse
);
  logic [NUM_RES-1:0] own_q [NUM_AGENTS];
  logic [NUM_RES-1:0] others;
  logic [NUM_RES-1:0] mine;

  // Union of every other agent's holdings decides what can be granted.
  always_comb begin
    others = '0;
    for (int j = 0; j < NUM_AGENTS; j++) begin
      if (j != int'(agent)) others |= own_q[j];
    end
    mine = own_q[agent];
    unique case (op)
      OP_SET:   misuse = |(mask & mine);
      OP_CLEAR: misuse = |(mask & ~mine);
      default:  misuse = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q[i] <= '0;
      end else if (agent == AGENT_W'(i)) begin
        if (op == OP_SET)        own_q[i] <= own_q[i] | (mask & ~others);
        else if (op == OP_CLEAR) own_q[i] <= own_q[i] & ~mask;
      end
    end
    assign own_flat[i*NUM_RES +: NUM_RES] = own_q[i];
  end
endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank
  import hwsem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_AGENTS = 16,
  parameter int NUM_RES = 32,
  parameter int LO_COUNT = 6,
  parameter logic [ADDR_W-1:0] BASE_A = 16'hA360,
  parameter logic [ADDR_W-1:0] BASE_B = 16'hA3C8,
  parameter logic [ADDR_W-1:0] IRQ_CLR_ADDR = 16'hA500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_RES-1:0] bus_wdata,
  output logic               rd_valid,
  output logic [NUM_RES-1:0] rd_data,
  output logic               irq
);
  localparam int AGENT_W = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1;

  logic                          hit, set_port, misuse, irq_clr;
  logic [AGENT_W-1:0]            agent;
  logic [NUM_AGENTS*NUM_RES-1:0] own_flat;
  sem_op_e                       op;

  hwsem_decode #(
    .ADDR_W(ADDR_W), .NUM_AGENTS(NUM_AGENTS), .LO_COUNT(LO_COUNT),
    .AGENT_W(AGENT_W), .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_decode (
    .addr(bus_addr), .hit(hit), .set_port(set_port), .agent(agent)
  );

  always_comb begin
    op = OP_NONE;
    if (bus_sel && bus_wr && hit) op = set_port ? OP_SET : OP_CLEAR;
    irq_clr = bus_sel && bus_wr && (bus_addr == IRQ_CLR_ADDR) && bus_wdata[0];
  end

  hwsem_owner_bank #(
    .NUM_AGENTS(NUM_AGENTS), .NUM_RES(NUM_RES), .AGENT_W(AGENT_W)
  ) u_owners (
    .clk(clk), .rst_n(rst_n), .op(op), .agent(agent), .mask(bus_wdata),
    .own_flat(own_flat), .misuse(misuse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      rd_valid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr)
        rd_data <= hit ? own_flat[int'(agent)*NUM_RES +: NUM_RES] : '0;
      if (irq_clr)     irq <= 1'b0;
      else if (misuse) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_AGENTS = 16,
  parameter int NUM_RES = 32,
  parameter logic [ADDR_W-1:0] IRQ_CLR_ADDR = 16'hA500
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [NUM_RES-1:0]            bus_wdata,
  input logic                          rd_valid,
  input logic                          irq,
  input logic [NUM_AGENTS*NUM_RES-1:0] own_flat
);
  logic clr_req;
  assign clr_req = bus_sel && bus_wr && (bus_addr == IRQ_CLR_ADDR) && bus_wdata[0];

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    logic [NUM_AGENTS-1:0] holders;
    always_comb begin
      for (int a = 0; a < NUM_AGENTS; a++) holders[a] = own_flat[a*NUM_RES + r];
    end
    AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holders) <= 1); // R2
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> rd_valid); // R11
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !rd_valid); // R11
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq); // R12
  AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(bus_sel && bus_wr)) |=> !irq); // R12
endmodule

bind hwsem_bank hwsem_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_AGENTS(NUM_AGENTS), .NUM_RES(NUM_RES),
  .IRQ_CLR_ADDR(IRQ_CLR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
  .irq(irq), .own_flat(own_flat)
);

// File: tb/hwsem_bank_test.sv
module hwsem_bank_test;
  localparam int NA = 16;
  localparam int NR = 32;
  localparam int LO = 6;
  localparam logic [15:0] BA = 16'hA360;
  localparam logic [15:0] BB = 16'hA3C8;
  localparam logic [15:0] ICLR = 16'hA500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [NR-1:0] bus_wdata = '0;
  logic rd_valid;
  logic [NR-1:0] rd_data;
  logic irq;

  logic [NR-1:0] model [NA];
  logic exp_irq = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hwsem_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, logic [NR-1:0] act, logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] win(int a, bit setp);
    logic [15:0] base;
    base = (a < LO) ? BA + 16'(a * 8) : BB + 16'((a - LO) * 8);
    return setp ? base + 16'd4 : base;
  endfunction

  task automatic bus_write(logic [15:0] addr, logic [NR-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] addr, output logic [NR-1:0] data, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    @(negedge clk);
    bus_sel = 1'b0;
    chk({req, "/R11 rd_valid"}, NR'(rd_valid), NR'(1));
    data = rd_data;
  endtask

  task automatic m_set(int a, logic [NR-1:0] d);
    logic [NR-1:0] others;
    others = '0;
    for (int j = 0; j < NA; j++) if (j != a) others |= model[j];
    if ((d & model[a]) != '0) exp_irq = 1'b1;
    model[a] = model[a] | (d & ~others);
    bus_write(win(a, 1'b1), d);
  endtask

  task automatic m_clr(int a, logic [NR-1:0] d);
    if ((d & ~model[a]) != '0) exp_irq = 1'b1;
    model[a] = model[a] & ~d;
    bus_write(win(a, 1'b0), d);
  endtask

  task automatic check_agent(int a, string req);
    logic [NR-1:0] v;
    bus_read(win(a, 1'b0), v, req);
    chk({req, " release-port read"}, v, model[a]);
    bus_read(win(a, 1'b1), v, req);
    chk({req, "/R9 acquire-port read"}, v, model[a]);
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < NA; a++) check_agent(a, req);
  endtask

  task automatic check_irq(string req);
    chk({req, " irq"}, NR'(irq), NR'(exp_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] v;
    for (int a = 0; a < NA; a++) model[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    check_irq("R1");
    check_all("R1");
    @(negedge clk);
    chk("R11 idle rd_valid", NR'(rd_valid), NR'(0));

    // R3 / R4: every resource claimed once, then contested by every other agent
    for (int b = 0; b < NR; b++) begin
      m_set(b % NA, NR'(1) << b);
      check_agent(b % NA, "R3");
      for (int o = 0; o < NA; o++) begin
        if (o != b % NA) begin
          m_set(o, NR'(1) << b);
          check_agent(o, "R4");
          check_irq("R4");
        end
      end
    end
    check_all("R2");

    // R7: release owned bits
    m_clr(0, 32'h0001_0001);
    check_agent(0, "R7");
    check_irq("R7");

    // R5: free bits 0/16 granted, bit 1 (held by agent 1) refused
    m_set(5, 32'h0001_0003);
    check_agent(5, "R5");
    check_agent(1, "R5 holder");
    check_irq("R5");
    chk("R5 expected word", model[5], 32'h0021_0021);

    // R6: re-acquire an owned bit
    m_set(5, 32'h0000_0020);
    check_irq("R6");
    check_agent(5, "R6");

    // R12: clear with bit0 = 0 does nothing, with bit0 = 1 clears
    bus_write(ICLR, 32'hFFFF_FFFE);
    check_irq("R12 no-clear");
    bus_write(ICLR, 32'h0000_0001);
    exp_irq = 1'b0;
    check_irq("R12 clear");
    check_all("R10 after irq-clear write");

    // R8: release an unowned bit
    m_clr(2, 32'h0000_0080);
    check_irq("R8");
    check_agent(2, "R8");
    bus_write(ICLR, 32'h1);
    exp_irq = 1'b0;
    check_irq("R12 clear again");

    // R10: undecoded and misaligned writes
    bus_write(BA + 16'd48, '1);
    bus_write(BB - 16'd8, '1);
    bus_write(BA + 16'd6, '1);
    bus_write(BB + 16'(8 * (NA - LO)), '1);
    check_all("R10");
    check_irq("R10");
    bus_read(BA + 16'd48, v, "R10");
    chk("R10 undecoded read", v, '0);
    bus_read(BA + 16'd2, v, "R10");
    chk("R10 misaligned read", v, '0);

    // R9 / R5: agent on the second range drops and re-claims mixed bits
    m_clr(9, 32'h0200_0200);
    m_set(9, 32'h0000_0600);
    check_agent(9, "R9");
    check_agent(10, "R4 holder");
    check_irq("R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule